// File: doc/BRIEF.md
# Multi-port SRAM access arbiter

This block lets three requesters share a single external synchronous SRAM. One port belongs to a drawing engine that only writes pixels. One belongs to a processor that both reads and writes. One belongs to a display refresh engine that only reads. Every cycle the arbiter picks at most one port by fixed priority, acknowledges it, and turns its request into a registered memory command: address, active-low write enable, active-low output enable, write data, and a write-drive enable. Ports that lose get no acknowledge and keep their request up until they are served.

Each port uses a request/acknowledge handshake. A requester drops its request in the cycle after it sees the acknowledge, unless it wants to continue a burst. A burst holds the grant for as long as the request stays high, except that the drawing port may take the memory over. Read data comes back through a short tag pipeline. A one-cycle valid pulse and the data go only to the port that issued the read.

Top module: `sram_port_arbiter`

## Requirements
- R1: Whenever drw_req is high, drw_ack is high in that same cycle, whatever the other ports request and whichever port held a burst.
- R2: Suppose no burst is being held and the drawing port is idle. If both dsp_req and cpu_req are high, dsp_ack is high and cpu_ack is low.
- R3: Suppose the processor or display port had its ack high in the previous cycle, still has its request high, and drw_req is low. That port's ack is high again, even if the other lower port is requesting.
- R4: At most one ack is high per cycle. A request that is held high until acknowledged always receives its ack.
- R5: The memory command appears in the cycle after the ack cycle, with mem_addr equal to the granted port's address. A write (drawing port, or processor with cpu_we=1) gives mem_we_n=0, mem_oe_n=1 and mem_wdata equal to the port's write data. A read (display port, or processor with cpu_we=0) gives mem_we_n=1 and mem_oe_n=0.
- R6: mem_wdrive is a registered copy of the write decision. It is high in the cycle after each cycle with mem_we_n=0, and low otherwise.
- R7: A read acknowledged in cycle n raises that port's rvalid for exactly one cycle, in cycle n+3. The rdata shown there is the word the SRAM returned for that read. The other port's rvalid stays low.
- R8: In the cycle after a cycle with no request, mem_we_n=1 and mem_oe_n=1, so no memory cycle is issued.
- R9: Synchronous reset (rst=1) clears all commands, valids and burst ownership: mem_we_n=1, mem_oe_n=1, mem_wdrive=0, both rvalid low. After reset, a simultaneous processor and display request goes to the display.
- R10: When all three ports request at once, a read served after a write to the same address returns the newly written data. Each port's read returns data for its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drw_req | input | 1 | Drawing port write request |
| drw_addr | input | AW | Drawing port address |
| drw_wdata | input | DW | Drawing port write data |
| drw_ack | output | 1 | Drawing port request accepted this cycle |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write flag (1 write, 0 read) |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ack | output | 1 | Processor request accepted this cycle |
| cpu_rvalid | output | 1 | Processor read data valid pulse |
| cpu_rdata | output | DW | Processor read data |
| dsp_req | input | 1 | Display refresh read request |
| dsp_addr | input | AW | Display refresh address |
| dsp_ack | output | 1 | Display request accepted this cycle |
| dsp_rvalid | output | 1 | Display read data valid pulse |
| dsp_rdata | output | DW | Display read data |
| mem_addr | output | AW | SRAM address |
| mem_we_n | output | 1 | SRAM write enable, active low |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_wdata | output | DW | SRAM write data |
| mem_wdrive | output | 1 | Data bus drive enable, one cycle behind write enable |
| mem_rdata | input | DW | SRAM read data (one-cycle synchronous) |

## Verification
The hardest case to reach is two reads in flight at once, with a write to the same address ahead of them in the queue. This is where a wrong tag or a missing write ordering shows up as swapped or stale data. The bench drives all three requests in the same cycle and lets each requester hold its line until acknowledged. It does this twice, with different addresses and data patterns. A burst-hold sequence is then interrupted by the drawing port, and a reset is applied while a burst is held.

// File: rtl/sram_port_arbiter.sv
module sram_port_arbiter #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drw_req,
  input  logic [AW-1:0] drw_addr,
  input  logic [DW-1:0] drw_wdata,
  output logic          drw_ack,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dsp_req,
  input  logic [AW-1:0] dsp_addr,
  output logic          dsp_ack,
  output logic          dsp_rvalid,
  output logic [DW-1:0] dsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdrive,
  input  logic [DW-1:0] mem_rdata
);

  localparam logic [1:0] P_NONE = 2'd0;
  localparam logic [1:0] P_DRW  = 2'd1;
  localparam logic [1:0] P_CPU  = 2'd2;
  localparam logic [1:0] P_DSP  = 2'd3;

  logic [1:0] owner, gnt, tag0, tag1;
  logic       gnt_rd;

  always_comb begin
    if (drw_req)                         gnt = P_DRW;
    else if (owner == P_CPU && cpu_req)  gnt = P_CPU;
    else if (owner == P_DSP && dsp_req)  gnt = P_DSP;
    else if (dsp_req)                    gnt = P_DSP;
    else if (cpu_req)                    gnt = P_CPU;
    else                                 gnt = P_NONE;
  end

  assign drw_ack = (gnt == P_DRW);
  assign cpu_ack = (gnt == P_CPU);
  assign dsp_ack = (gnt == P_DSP);
  assign gnt_rd  = (gnt == P_DSP) || (gnt == P_CPU && !cpu_we);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner      <= P_NONE;
      mem_addr   <= '0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_wdata  <= '0;
      mem_wdrive <= 1'b0;
      tag0       <= P_NONE;
      tag1       <= P_NONE;
      cpu_rvalid <= 1'b0;
      dsp_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      dsp_rdata  <= '0;
    end else begin
      owner <= gnt;
      case (gnt)
        P_DRW: begin
          mem_addr  <= drw_addr;
          mem_we_n  <= 1'b0;
          mem_oe_n  <= 1'b1;
          mem_wdata <= drw_wdata;
        end
        P_CPU: begin
          mem_addr <= cpu_addr;
          mem_we_n <= !cpu_we;
          mem_oe_n <= cpu_we;
          if (cpu_we) mem_wdata <= cpu_wdata;
        end
        P_DSP: begin
          mem_addr <= dsp_addr;
          mem_we_n <= 1'b1;
          mem_oe_n <= 1'b0;
        end
        default: begin
          mem_we_n <= 1'b1;
          mem_oe_n <= 1'b1;
        end
      endcase
      mem_wdrive <= !mem_we_n;
      tag0       <= gnt_rd ? gnt : P_NONE;
      tag1       <= tag0;
      cpu_rvalid <= (tag1 == P_CPU);
      dsp_rvalid <= (tag1 == P_DSP);
      if (tag1 == P_CPU) cpu_rdata <= mem_rdata;
      if (tag1 == P_DSP) dsp_rdata <= mem_rdata;
    end
  end

  // R1
  drw_first_chk: assert property (@(posedge clk) disable iff (rst)
    drw_req |-> drw_ack);

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_ack) && cpu_req && !drw_req) |-> cpu_ack);

  // R5
  wr_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    drw_ack |=> (!mem_we_n && mem_oe_n && mem_addr == $past(drw_addr)));

  // R5
  rd_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_ack |=> (mem_we_n && !mem_oe_n && mem_addr == $past(dsp_addr)));

  // R6
  drive_lag_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> mem_wdrive);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(drw_req || cpu_req || dsp_req) |=> (mem_we_n && mem_oe_n));

  // R7
  rv_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rvalid && dsp_rvalid));

endmodule

// File: tb/sram_port_arbiter_test.sv
module sram_port_arbiter_test;
  logic clk = 1'b0, rst = 1'b1;
  logic drw_req = 0, cpu_req = 0, cpu_we = 0, dsp_req = 0;
  logic [20:0] drw_addr = '0, cpu_addr = '0, dsp_addr = '0;
  logic [15:0] drw_wdata = '0, cpu_wdata = '0;
  logic drw_ack, cpu_ack, dsp_ack, cpu_rvalid, dsp_rvalid;
  logic [15:0] cpu_rdata, dsp_rdata, mem_wdata, mem_rdata;
  logic [20:0] mem_addr;
  logic mem_we_n, mem_oe_n, mem_wdrive;
  int nerr = 0, nchk = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_port_arbiter uut (
    .clk(clk), .rst(rst),
    .drw_req(drw_req), .drw_addr(drw_addr), .drw_wdata(drw_wdata), .drw_ack(drw_ack),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .dsp_req(dsp_req), .dsp_addr(dsp_addr), .dsp_ack(dsp_ack),
    .dsp_rvalid(dsp_rvalid), .dsp_rdata(dsp_rdata),
    .mem_addr(mem_addr), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_wdata(mem_wdata), .mem_wdrive(mem_wdrive), .mem_rdata(mem_rdata));

  logic [15:0] sram [256];
  logic [15:0] shadow [256];
  initial begin
    for (int i = 0; i < 256; i++) begin sram[i] = '0; shadow[i] = '0; end
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (!mem_we_n) sram[mem_addr[7:0]] <= mem_wdata;
    if (!mem_oe_n) mem_rdata <= sram[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {drw,cpu,dsp request} -> {drw,cpu,dsp expected ack}, no burst owner
  localparam logic [5:0] ARB_VEC [8] = '{
    6'b000_000, 6'b001_001, 6'b010_010, 6'b011_001,
    6'b100_100, 6'b101_100, 6'b110_100, 6'b111_100 };

  bit p_drw, p_cpu, p_dsp;

  task automatic run_all(input int ncyc);
    int drw_c = -100, cpu_c = -100, dsp_c = -100;
    logic [15:0] cpu_exp = '0, dsp_exp = '0;
    bit cpu_rd = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      drw_req = p_drw; cpu_req = p_cpu; dsp_req = p_dsp;
      #1;
      chk(int'(drw_ack) + int'(cpu_ack) + int'(dsp_ack) <= 1, "R4 one ack",
          {drw_ack, cpu_ack, dsp_ack}, 0);
      if (p_drw) chk(drw_ack, "R1 draw wins", drw_ack, 1);
      if (c == drw_c + 1)
        chk(!mem_we_n && mem_addr == drw_addr && mem_wdata == drw_wdata, "R5 write cmd",
            mem_addr, drw_addr);
      if (c == drw_c + 2) chk(mem_wdrive, "R6 drive lag", mem_wdrive, 1);
      chk(cpu_rvalid == (cpu_rd && c == cpu_c + 3), "R7 cpu rvalid timing", cpu_rvalid,
          cpu_rd && c == cpu_c + 3);
      chk(dsp_rvalid == (c == dsp_c + 3), "R7 dsp rvalid timing", dsp_rvalid, c == dsp_c + 3);
      if (cpu_rvalid) chk(cpu_rdata == cpu_exp, "R10 cpu data", cpu_rdata, cpu_exp);
      if (dsp_rvalid) chk(dsp_rdata == dsp_exp, "R10 dsp data", dsp_rdata, dsp_exp);
      if (drw_ack) begin
        drw_c = c; p_drw = 0; shadow[drw_addr[7:0]] = drw_wdata;
      end
      if (cpu_ack) begin
        cpu_c = c; p_cpu = 0; cpu_rd = !cpu_we;
        if (cpu_we) shadow[cpu_addr[7:0]] = cpu_wdata; else cpu_exp = shadow[cpu_addr[7:0]];
      end
      if (dsp_ack) begin
        dsp_c = c; p_dsp = 0; dsp_exp = shadow[dsp_addr[7:0]];
      end
    end
    chk(!p_drw && !p_cpu && !p_dsp, "R4 no lost ack", {p_drw, p_cpu, p_dsp}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_we_n && mem_oe_n && !mem_wdrive, "R9 reset cmd", {mem_we_n, mem_oe_n, mem_wdrive}, 3'b110);
    chk(!cpu_rvalid && !dsp_rvalid, "R9 reset valid", {cpu_rvalid, dsp_rvalid}, 0);
    rst = 0;

    for (int i = 0; i < 8; i++) begin
      logic [5:0] v = ARB_VEC[i];
      logic [20:0] ea;
      @(negedge clk);
      drw_addr = 21'(16 + i); cpu_addr = 21'(32 + i); dsp_addr = 21'(48 + i);
      drw_wdata = 16'(16'h100 + i); cpu_we = 0;
      drw_req = v[5]; cpu_req = v[4]; dsp_req = v[3];
      #1;
      chk({drw_ack, cpu_ack, dsp_ack} == v[2:0], "R1/R2 table ack R2", {drw_ack, cpu_ack, dsp_ack}, v[2:0]);
      @(negedge clk);
      drw_req = 0; cpu_req = 0; dsp_req = 0;
      ea = v[2] ? drw_addr : v[1] ? cpu_addr : dsp_addr;
      if (v[2:0] == 3'b000)
        chk(mem_we_n && mem_oe_n, "R8 idle no cycle", {mem_we_n, mem_oe_n}, 2'b11);
      else begin
        chk(mem_addr == ea, "R5 table address", mem_addr, ea);
        chk(mem_we_n == !v[2] && mem_oe_n == v[2], "R5 table direction", {mem_we_n, mem_oe_n}, {!v[2], v[2]});
      end
      if (v[2]) shadow[drw_addr[7:0]] = drw_wdata;
    end
    repeat (5) @(negedge clk);

    // R10 scenario A: write 5, cpu write 9, display reads 5
    drw_addr = 5; drw_wdata = 16'hA5A5; cpu_addr = 9; cpu_we = 1; cpu_wdata = 16'h1234; dsp_addr = 5;
    p_drw = 1; p_cpu = 1; p_dsp = 1;
    run_all(8);
    // R10 scenario B: write 9, cpu reads 9, display reads 5
    drw_addr = 9; drw_wdata = 16'h0F0F; cpu_addr = 9; cpu_we = 0; dsp_addr = 5;
    p_drw = 1; p_cpu = 1; p_dsp = 1;
    run_all(8);
    @(negedge clk); #1;
    chk(mem_we_n && mem_oe_n && !mem_wdrive, "R8 idle after traffic", {mem_we_n, mem_oe_n, mem_wdrive}, 3'b110);

    // R3 burst hold, then draw preemption, then display over cpu
    @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = 70; cpu_wdata = 16'h7777; #1;
    chk(cpu_ack, "R3 burst start", cpu_ack, 1);
    @(negedge clk); dsp_req = 1; dsp_addr = 71; #1;
    chk(cpu_ack && !dsp_ack, "R3 burst hold 1", {cpu_ack, dsp_ack}, 2'b10);
    @(negedge clk); #1;
    chk(cpu_ack && !dsp_ack, "R3 burst hold 2", {cpu_ack, dsp_ack}, 2'b10);
    @(negedge clk); drw_req = 1; drw_addr = 72; #1;
    chk(drw_ack && !cpu_ack, "R1 preempt burst", {drw_ack, cpu_ack}, 2'b10);
    @(negedge clk); drw_req = 0; #1;
    chk(dsp_ack && !cpu_ack, "R2 display after preempt", {dsp_ack, cpu_ack}, 2'b10);
    @(negedge clk); #1;
    chk(dsp_ack, "R3 display burst hold", dsp_ack, 1);

    // R9 reset while a burst is held and a write command is out
    @(negedge clk); dsp_req = 0; drw_req = 1; #1;
    @(negedge clk); rst = 1; drw_req = 0; cpu_req = 0;
    @(negedge clk);
    chk(mem_we_n && mem_oe_n && !mem_wdrive, "R9 mid reset cmd", {mem_we_n, mem_oe_n, mem_wdrive}, 3'b110);
    rst = 0;
    @(negedge clk); cpu_req = 1; dsp_req = 1; #1;
    chk(dsp_ack && !cpu_ack, "R9 owner cleared", {dsp_ack, cpu_ack}, 2'b10);
    @(negedge clk); cpu_req = 0; dsp_req = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule